// File: doc/BRIEF.md
# Audio Bit-Clock and Master-Clock Divider

This block turns a fast kernel clock into the timing of a serial audio port. A prescaler divides the kernel clock by a programmable ratio of 2*DIV+ODD, so odd ratios are possible. DIV is an 8-bit field and ODD is a single bit. Each stage reports its result as a one-cycle clock-enable pulse at the start of every output period, plus a level reference that is high for the first part of the period. Downstream logic can register data on the pulse, or retime the level to make a pin.

With the master-clock output switched on, the prescaler output becomes the master clock. A fixed post-divider then derives the bit clock from it. Its ratio follows from the master clock running at 256 times the frame rate in the two-slot standard and 128 times the frame rate in the short-frame PCM standard. With the master clock switched off, the prescaler output is the bit clock. Settings that cannot be honoured raise an error flag and are not loaded. Every change waits for the current period to finish.

Top module: `aclk_gen`

## Requirements
- R1: For a legal setting with DIV>0, the bit-clock enable `bclk_tick_o` pulses once every 2*DIV+ODD kernel cycles when `mclk_en_i`=0.
- R2: DIV=0 gives a ratio of 1 for either ODD value: `bclk_tick_o` and `bclk_ref_o` are high on every cycle.
- R3: In each prescaler period of N cycles, the reference is high for the first ceil(N/2) cycles, starting on the pulse cycle, and low for the remaining floor(N/2).
- R4: DIV=1 with ODD=1 is illegal. `cfg_err_o` goes high one cycle after it is presented, and the running ratio is kept. For every legal setting, `cfg_err_o` is low.
- R5: DIV above 127 is illegal and is handled like R4. DIV=127 with ODD=1 is legal and gives 255.
- R6: A new DIV or ODD takes effect only at the next period boundary. The period in progress completes at the old ratio.
- R7: With `mclk_en_i`=1, `mclk_tick_o` pulses once per prescaler period, and `mclk_ref_o` follows the R3 duty. `bclk_tick_o` pulses every P prescaler periods. P=8 with `wide_i`=0 and P=4 with `wide_i`=1, for both `std_i`=0 (two-slot, 256 master clocks per frame, 32 or 64 bits) and `std_i`=1 (PCM, 128 per frame, 16 or 32 bits). `bclk_ref_o` is high for the first P/2 prescaler periods.
- R8: With `mclk_en_i`=0, `mclk_tick_o` and `mclk_ref_o` stay low.
- R9: While `rst_ni` is low, and for two cycles after it rises, all outputs and `cfg_err_o` are low. On the third cycle, `bclk_tick_o` and `bclk_ref_o` are high and the first period begins.
- R10: Changes to `mclk_en_i`, `std_i` or `wide_i` take effect only at a bit-clock period boundary. The bit period in progress completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| div_i | input | 8 | Prescaler field DIV |
| odd_i | input | 1 | Odd flag ODD, adds one to the ratio |
| mclk_en_i | input | 1 | 1: prescaler drives the master clock and the bit clock is derived from it |
| std_i | input | 1 | Framing standard, 0 two-slot, 1 short-frame PCM |
| wide_i | input | 1 | 1: double-length slots |
| mclk_tick_o | output | 1 | Master-clock enable pulse |
| mclk_ref_o | output | 1 | Master-clock level reference |
| bclk_tick_o | output | 1 | Bit-clock enable pulse |
| bclk_ref_o | output | 1 | Bit-clock level reference |
| cfg_err_o | output | 1 | Registered illegal-setting flag |

## Verification
The embedded properties assume the configuration inputs are synchronous to the kernel clock and settle before the edge that samples them. The bench meets this by changing them only on falling edges. The properties also assume that a rejected setting is not a reason to reload, so the hold checks apply to every non-boundary cycle, legal or not. The stimulus sweeps small and near-maximum DIV values with both ODD settings, and all four standard and slot-width combinations. It also changes settings in the middle of a period, so the boundary rules are exercised with live traffic on the outputs.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

  typedef enum logic {
    STD_I2S = 1'b0,
    STD_PCM = 1'b1
  } aclk_std_e;

  typedef struct packed {
    logic      mclk_mode;
    aclk_std_e std;
    logic      wide;
  } aclk_post_cfg_t;

endpackage

// File: rtl/aclk_cfg_check.sv
module aclk_cfg_check #(
  parameter int DIV_W   = 8,
  parameter int DIV_MAX = 127
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             odd_i,
  output logic             legal_o,
  output logic             err_o
);

  logic too_big, bad_pair, err_d, err_q;

  always_comb begin
    too_big  = div_i > DIV_W'(DIV_MAX);
    bad_pair = (div_i == DIV_W'(1)) && odd_i;
    legal_o  = !(too_big || bad_pair);
    err_d    = !legal_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_d;
  end

  assign err_o = err_q;

  assert_flag_pair_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_i == DIV_W'(1) && odd_i) |=> err_o);

endmodule

// File: rtl/aclk_prescaler.sv
module aclk_prescaler #(
  parameter int DIV_W   = 8,
  parameter int DIV_MAX = 127
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             odd_i,
  input  logic             legal_i,
  output logic             tick_o,
  output logic             ref_o,
  output logic             wrap_o,
  output logic             live_o
);

  localparam int RW = DIV_W + 1;
  localparam logic [RW-1:0] ONE = RW'(1);
  localparam logic [RW-1:0] RATIO_CAP = RW'(2 * DIV_MAX + 1);

  logic [RW-1:0] cnt_q, cnt_d;
  logic [RW-1:0] ratio_q, ratio_d;
  logic [RW-1:0] hi_q, hi_d;
  logic [RW-1:0] ratio_new, hi_new;
  logic          live_q, wrap;

  // next-state
  always_comb begin
    ratio_new = (div_i == '0) ? ONE : ({div_i, 1'b0} + RW'(odd_i));
    hi_new    = (ratio_new >> 1) + RW'(ratio_new[0]);
    wrap      = (cnt_q == ratio_q - ONE);
    ratio_d   = ratio_q;
    hi_d      = hi_q;
    if (wrap) begin
      cnt_d = '0;
      if (legal_i) begin
        ratio_d = ratio_new;
        hi_d    = hi_new;
      end
    end else begin
      cnt_d = cnt_q + ONE;
    end
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ratio_q <= ONE;
      hi_q    <= ONE;
      live_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
      hi_q    <= hi_d;
      live_q  <= 1'b1;
    end
  end

  assign tick_o = live_q && (cnt_q == '0);
  assign ref_o  = live_q && (cnt_q < hi_q);
  assign wrap_o = wrap;
  assign live_o = live_q;

  assert_cnt_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < ratio_q);

  assert_hold_mid_period_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> $stable(ratio_q));

  assert_reject_illegal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && !legal_i) |=> $stable(ratio_q) && $stable(hi_q));

  assert_ratio_cap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_q <= RATIO_CAP);

endmodule

// File: rtl/aclk_post_div.sv
module aclk_post_div
  import aclk_pkg::*;
#(
  parameter int MCLK_FS_I2S = 256,
  parameter int MCLK_FS_PCM = 128,
  parameter int SLOT_I2S    = 32,
  parameter int SLOT_PCM    = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           live_i,
  input  logic           a_tick_i,
  input  logic           a_ref_i,
  input  logic           a_wrap_i,
  input  aclk_post_cfg_t cfg_i,
  output logic           mclk_tick_o,
  output logic           mclk_ref_o,
  output logic           bclk_tick_o,
  output logic           bclk_ref_o
);

  localparam int P_I2S_N = MCLK_FS_I2S / SLOT_I2S;
  localparam int P_I2S_W = MCLK_FS_I2S / (2 * SLOT_I2S);
  localparam int P_PCM_N = MCLK_FS_PCM / SLOT_PCM;
  localparam int P_PCM_W = MCLK_FS_PCM / (2 * SLOT_PCM);
  localparam int P_MAX   = (P_I2S_N > P_PCM_N) ? P_I2S_N : P_PCM_N;
  localparam int PW      = $clog2(P_MAX) + 1;

  aclk_post_cfg_t cur_q, cur_d;
  logic [PW-1:0]  p_q, p_d, p_new, pcnt_q, pcnt_d, last;
  logic           boundary;

  // next-state
  always_comb begin
    unique case ({cfg_i.std, cfg_i.wide})
      {STD_I2S, 1'b0}: p_new = PW'(P_I2S_N);
      {STD_I2S, 1'b1}: p_new = PW'(P_I2S_W);
      {STD_PCM, 1'b0}: p_new = PW'(P_PCM_N);
      default:         p_new = PW'(P_PCM_W);
    endcase
    last     = cur_q.mclk_mode ? (p_q - PW'(1)) : '0;
    boundary = a_wrap_i && (pcnt_q == last);
    cur_d    = cur_q;
    p_d      = p_q;
    pcnt_d   = pcnt_q;
    if (boundary) begin
      pcnt_d = '0;
      cur_d  = cfg_i;
      p_d    = p_new;
    end else if (a_wrap_i) begin
      pcnt_d = pcnt_q + PW'(1);
    end
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '{mclk_mode: 1'b0, std: STD_I2S, wide: 1'b0};
      p_q    <= PW'(P_I2S_N);
      pcnt_q <= '0;
    end else begin
      cur_q  <= cur_d;
      p_q    <= p_d;
      pcnt_q <= pcnt_d;
    end
  end

  always_comb begin
    mclk_tick_o = cur_q.mclk_mode && a_tick_i;
    mclk_ref_o  = cur_q.mclk_mode && a_ref_i;
    bclk_tick_o = a_tick_i && (pcnt_q == '0);
    bclk_ref_o  = cur_q.mclk_mode ? (live_i && (pcnt_q < (p_q >> 1))) : a_ref_i;
  end

  assert_pcnt_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_q.mclk_mode |-> (pcnt_q < p_q));

  assert_cfg_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boundary |=> $stable(cur_q) && $stable(p_q));

endmodule

// File: rtl/aclk_gen.sv
module aclk_gen
  import aclk_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int DIV_MAX     = 127,
  parameter int MCLK_FS_I2S = 256,
  parameter int MCLK_FS_PCM = 128,
  parameter int SLOT_I2S    = 32,
  parameter int SLOT_PCM    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             odd_i,
  input  logic             mclk_en_i,
  input  logic             std_i,
  input  logic             wide_i,
  output logic             mclk_tick_o,
  output logic             mclk_ref_o,
  output logic             bclk_tick_o,
  output logic             bclk_ref_o,
  output logic             cfg_err_o
);

  logic [1:0]     sync_q, sync_d;
  logic           rst_int_n;
  logic           legal, a_tick, a_ref, a_wrap, live;
  aclk_post_cfg_t post_cfg;

  // reset release synchroniser
  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign rst_int_n = sync_q[1];

  always_comb begin
    post_cfg.mclk_mode = mclk_en_i;
    post_cfg.std       = aclk_std_e'(std_i);
    post_cfg.wide      = wide_i;
  end

  aclk_cfg_check #(.DIV_W(DIV_W), .DIV_MAX(DIV_MAX)) u_check (
    .clk_i   (clk_i),
    .rst_ni  (rst_int_n),
    .div_i   (div_i),
    .odd_i   (odd_i),
    .legal_o (legal),
    .err_o   (cfg_err_o)
  );

  aclk_prescaler #(.DIV_W(DIV_W), .DIV_MAX(DIV_MAX)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_int_n),
    .div_i   (div_i),
    .odd_i   (odd_i),
    .legal_i (legal),
    .tick_o  (a_tick),
    .ref_o   (a_ref),
    .wrap_o  (a_wrap),
    .live_o  (live)
  );

  aclk_post_div #(
    .MCLK_FS_I2S (MCLK_FS_I2S),
    .MCLK_FS_PCM (MCLK_FS_PCM),
    .SLOT_I2S    (SLOT_I2S),
    .SLOT_PCM    (SLOT_PCM)
  ) u_post (
    .clk_i       (clk_i),
    .rst_ni      (rst_int_n),
    .live_i      (live),
    .a_tick_i    (a_tick),
    .a_ref_i     (a_ref),
    .a_wrap_i    (a_wrap),
    .cfg_i       (post_cfg),
    .mclk_tick_o (mclk_tick_o),
    .mclk_ref_o  (mclk_ref_o),
    .bclk_tick_o (bclk_tick_o),
    .bclk_ref_o  (bclk_ref_o)
  );

  assert_first_period_R9: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    $rose(live) |-> (bclk_tick_o && bclk_ref_o));

endmodule

// File: tb/tb_aclk_gen.sv
module tb_aclk_gen;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] div;
  logic       odd, men, std, wide;
  logic       mclk_tick, mclk_ref, bclk_tick, bclk_ref, cfg_err;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #5 clk = ~clk;

  aclk_gen dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .div_i       (div),
    .odd_i       (odd),
    .mclk_en_i   (men),
    .std_i       (std),
    .wide_i      (wide),
    .mclk_tick_o (mclk_tick),
    .mclk_ref_o  (mclk_ref),
    .bclk_tick_o (bclk_tick),
    .bclk_ref_o  (bclk_ref),
    .cfg_err_o   (cfg_err)
  );

  task automatic check_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int d, input bit o, input bit m, input bit s, input bit w);
    div  = d[7:0];
    odd  = o;
    men  = m;
    std  = s;
    wide = w;
  endtask

  task automatic sync_tick();
    int g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!bclk_tick && g < 5000);
  endtask

  task automatic measure(output int len, output int hi, output int mt, output int mr);
    len = 0; hi = 0; mt = 0; mr = 0;
    do begin
      if (bclk_ref)  hi++;
      if (mclk_tick) mt++;
      if (mclk_ref)  mr++;
      len++;
      @(negedge clk);
    end while (!bclk_tick && len < 5000);
  endtask

  task automatic remainder(output int n);
    n = 1;
    while (!bclk_tick && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    int len, hi, mt, mr, n, p;
    rst_n = 1'b0;
    set_cfg(1, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    // R9: quiet in reset
    check_eq("R9 reset outputs", int'(bclk_tick) + int'(bclk_ref) + int'(mclk_tick)
             + int'(mclk_ref) + int'(cfg_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R9 release cycle1", int'(bclk_tick) + int'(bclk_ref), 0);
    @(negedge clk);
    check_eq("R9 release cycle2", int'(bclk_tick) + int'(bclk_ref), 0);
    @(negedge clk);
    check_eq("R9 first tick", int'(bclk_tick && bclk_ref), 1);

    // R1 R2 R3 R8 sweep in direct mode
    for (int d = 0; d <= 127; d++) begin
      if (d <= 24 || d >= 120) begin
        for (int o = 0; o < 2; o++) begin
          if (!(d == 1 && o == 1)) begin
            set_cfg(d, o[0], 0, 0, 0);
            sync_tick();
            n = (d == 0) ? 1 : 2 * d + o;
            check_eq("R4 legal no flag", int'(cfg_err), 0);
            measure(len, hi, mt, mr);
            check_eq("R1 period", len, n);
            check_eq("R3 high phase", hi, (n + 1) / 2);
            check_eq("R8 mclk quiet", mt + mr, 0);
            if (n == 1) begin
              for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                check_eq("R2 bypass", int'(bclk_tick && bclk_ref), 1);
              end
            end
          end
        end
      end
    end

    // R4 R5 illegal settings keep ratio 5
    set_cfg(2, 1, 0, 0, 0);
    sync_tick();
    measure(len, hi, mt, mr);
    check_eq("R1 ratio five", len, 5);
    set_cfg(1, 1, 0, 0, 0);
    @(negedge clk);
    check_eq("R4 flag", int'(cfg_err), 1);
    sync_tick();
    measure(len, hi, mt, mr);
    check_eq("R4 ratio kept", len, 5);
    set_cfg(200, 0, 0, 0, 0);
    @(negedge clk);
    check_eq("R5 flag", int'(cfg_err), 1);
    sync_tick();
    measure(len, hi, mt, mr);
    check_eq("R5 ratio kept", len, 5);
    set_cfg(128, 1, 0, 0, 0);
    @(negedge clk);
    check_eq("R5 flag 128", int'(cfg_err), 1);
    sync_tick();
    measure(len, hi, mt, mr);
    check_eq("R5 ratio kept 128", len, 5);
    set_cfg(127, 1, 0, 0, 0);
    @(negedge clk);
    check_eq("R5 max legal flag", int'(cfg_err), 0);
    sync_tick();
    measure(len, hi, mt, mr);
    check_eq("R5 max ratio", len, 255);

    // R6 change mid period
    set_cfg(3, 0, 0, 0, 0);
    sync_tick();
    measure(len, hi, mt, mr);
    check_eq("R1 ratio six", len, 6);
    @(negedge clk);
    set_cfg(5, 0, 0, 0, 0);
    remainder(n);
    check_eq("R6 old period completes", n, 6);
    measure(len, hi, mt, mr);
    check_eq("R6 new period", len, 10);

    // R7 master clock mode, all standards and slot widths
    for (int s = 0; s < 2; s++) begin
      for (int w = 0; w < 2; w++) begin
        for (int c = 0; c < 3; c++) begin
          int dd = (c == 0) ? 0 : ((c == 1) ? 1 : 2);
          bit oo = (c == 2);
          int nn = (c == 0) ? 1 : ((c == 1) ? 2 : 5);
          p = (w == 1) ? 4 : 8;
          set_cfg(dd, oo, 1, s[0], w[0]);
          sync_tick();
          measure(len, hi, mt, mr);
          check_eq("R7 bclk period", len, nn * p);
          check_eq("R7 bclk high", hi, nn * p / 2);
          check_eq("R7 mclk ticks", mt, p);
          check_eq("R7 mclk high", mr, p * ((nn + 1) / 2));
        end
      end
    end

    // R10 mode and slot changes wait for the bit boundary
    set_cfg(1, 0, 1, 0, 0);
    sync_tick();
    measure(len, hi, mt, mr);
    check_eq("R7 base period", len, 16);
    @(negedge clk);
    set_cfg(1, 0, 1, 0, 1);
    remainder(n);
    check_eq("R10 slot change deferred", n, 16);
    measure(len, hi, mt, mr);
    check_eq("R10 wide period", len, 8);
    @(negedge clk);
    set_cfg(1, 0, 0, 0, 1);
    remainder(n);
    check_eq("R10 mode change deferred", n, 8);
    measure(len, hi, mt, mr);
    check_eq("R10 direct period", len, 2);
    check_eq("R8 mclk off", mt + mr, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule